// File: doc/BRIEF.md
# Priority Multi-Queue Transfer Scheduler

This block is a data-movement engine that sits between a requester and a set of memory-side ports. A requester places transfer descriptors into one of four ordered queues. Each descriptor names a source address, a destination address, a destination port and a count of 64-bit words. The engine turns the head descriptor of each queue into a stream of single-beat reads. It chooses one queue per cycle by fixed priority, so transfers held in different queues interleave beat by beat on one shared 64-bit path.

Each destination port has a credit counter. The counter tracks how many landing slots that port still has free. A read is issued only when its port has a slot to receive the returning beat. A queue whose port is full therefore waits without holding up queues that target other ports. Each read carries an opaque context word that the source returns unchanged with the data. The engine uses this context to steer the beat onto the right write port and to raise a completion pulse, tagged with the queue index, when the last beat of a transfer is written.

Top module: `xfer_sched`

## Requirements
- R1: Each of the four queues holds up to 4 descriptors. `req_full[q]` is high exactly while queue q holds 4. A request offered to a full queue is discarded and causes no read or write.
- R2: A request whose word count is zero is discarded at enqueue. It causes no read, no write and no completion.
- R3: Queue 0 has the highest priority and queue 3 the lowest. In any cycle at most one read is issued, and it goes to the lowest-index queue whose head descriptor is eligible.
- R4: Inside one queue, every beat of a transfer issues before any beat of the next transfer. Transfers finish in the order the queue accepted them.
- R5: A transfer of N words issues exactly N reads. Beat i reads source address src+8*i and writes destination address dst+8*i.
- R6: Each destination port starts with 4 credits after reset, and every read aimed at that port uses one. A head is eligible only while its port has a nonzero credit. A queue blocked by credit does not stop a lower-priority queue that targets another port.
- R7: A one-cycle pulse on `dst_free[p]` returns one credit to port p, capped at 4. With one blocked head waiting, each pulse allows exactly one more read to that port.
- R8: `rd_ctx` is returned by the source on `rdata_ctx` together with the data, and its bits [1:0] hold the issuing queue index. A returned beat appears on the write port one cycle after `rdata_valid`, with the data unchanged and `wr_valid` one-hot on the destination port.
- R9: `done_valid` pulses, with `done_qid` equal to the queue index, in the same cycle as the write of a transfer's last beat, and at no other time.
- R10: After reset no read, write or completion is signalled, and every `req_full` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered this cycle |
| req_qid | input | 2 | Target queue index |
| req_src | input | 32 | Source byte address |
| req_dst | input | 32 | Destination byte address |
| req_port | input | 1 | Destination port index |
| req_words | input | 8 | Number of 64-bit words |
| req_full | output | 4 | Per-queue full flag |
| rd_valid | output | 1 | Read request issued |
| rd_addr | output | 32 | Read byte address |
| rd_ctx | output | 36 | Context returned with the data (bits [1:0] queue index) |
| rdata_valid | input | 1 | Returned beat valid |
| rdata | input | 64 | Returned data |
| rdata_ctx | input | 36 | Context of the returned beat |
| wr_valid | output | 2 | One-hot write strobe per destination port |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write data |
| dst_free | input | 2 | Per-port slot-drained pulse |
| done_valid | output | 1 | Transfer completed |
| done_qid | output | 2 | Queue of the completed transfer |

## Verification
The bench starves one port of credit and then fills three queues behind it. A design that ignored credit would overrun that port, and one that stalled globally would also freeze a queue that targets the other port. It then returns credits one pulse at a time and checks which queue wins each single read. This would expose a wrong priority order, a counter that releases more than one read per returned slot, and a queue that lets its second transfer overtake its first. It also fills one queue to four entries and offers a fifth request and a zero-word request. A design that accepted either would produce reads or writes the scoreboard never expected. A design that pulsed completion on the wrong beat or with the wrong tag would be flagged on every write.

// File: rtl/xs_pkg.sv
package xs_pkg;

    localparam int NQ         = 4;
    localparam int NDST       = 2;
    localparam int AW         = 32;
    localparam int DW         = 64;
    localparam int CW         = 8;
    localparam int BEAT_BYTES = DW / 8;

    localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1;
    localparam int PW  = (NDST > 1) ? $clog2(NDST) : 1;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [PW-1:0] port;
        logic [CW-1:0] words;
    } desc_t;

    typedef struct packed {
        logic          last;
        logic [AW-1:0] dst;
        logic [PW-1:0] port;
        logic [QIW-1:0] qid;
    } ctx_t;

    localparam int CTXW = $bits(ctx_t);

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
        return a + AW'(BEAT_BYTES);
    endfunction

endpackage

// File: rtl/xs_queue.sv
module xs_queue
    import xs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  desc_t push_desc,
    input  logic  advance,
    output logic  full,
    output logic  head_valid,
    output desc_t head,
    output logic  head_last
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    desc_t            slots [DEPTH];
    logic [PTRW-1:0]  wr_ptr;
    logic [PTRW-1:0]  rd_ptr;
    logic [CNTW-1:0]  cnt;
    logic             pop;

    assign head       = slots[rd_ptr];
    assign head_valid = (cnt != '0);
    assign head_last  = (head.words == CW'(1));
    assign full       = (cnt == CNTW'(DEPTH));
    assign pop        = advance && head_last;

    // storage: new entries at the tail, in-place stepping of the head
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_desc;
        end
        if (advance && !head_last) begin
            slots[rd_ptr].src   <= step_addr(head.src);
            slots[rd_ptr].dst   <= step_addr(head.dst);
            slots[rd_ptr].words <= head.words - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTRW'(1);
            if (pop)  rd_ptr <= rd_ptr + PTRW'(1);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end

endmodule

// File: rtl/xs_credit.sv
module xs_credit #(
    parameter int NDST    = 2,
    parameter int CREDITS = 4,
    parameter int CRW     = $clog2(CREDITS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NDST-1:0]           take,
    input  logic [NDST-1:0]           ret,
    output logic [NDST-1:0]           avail,
    output logic [NDST-1:0][CRW-1:0]  level
);
    logic [CRW-1:0] cnt_q [NDST];

    for (genvar p = 0; p < NDST; p++) begin : g_port
        logic ret_ok;
        assign ret_ok   = ret[p] && (cnt_q[p] != CRW'(CREDITS));
        assign avail[p] = (cnt_q[p] != '0);
        assign level[p] = cnt_q[p];

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[p] <= CRW'(CREDITS);
            end else begin
                unique case ({take[p], ret_ok})
                    2'b10:   cnt_q[p] <= cnt_q[p] - CRW'(1);
                    2'b01:   cnt_q[p] <= cnt_q[p] + CRW'(1);
                    default: cnt_q[p] <= cnt_q[p];
                endcase
            end
        end
    end

endmodule

// File: rtl/xs_prio_arb.sv
module xs_prio_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/xs_writer.sv
module xs_writer
    import xs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  ctx_t             in_ctx,
    output logic [NDST-1:0]  wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             done_valid,
    output logic [QIW-1:0]   done_qid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid   <= '0;
            done_valid <= 1'b0;
        end else begin
            wr_valid   <= in_valid ? (NDST'(1) << in_ctx.port) : '0;
            done_valid <= in_valid && in_ctx.last;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            wr_addr  <= in_ctx.dst;
            wr_data  <= in_data;
            done_qid <= in_ctx.qid;
        end
    end

endmodule

// File: rtl/xfer_sched.sv
module xfer_sched
    import xs_pkg::*;
#(
    parameter int QDEPTH  = 4,
    parameter int CREDITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [QIW-1:0]   req_qid,
    input  logic [AW-1:0]    req_src,
    input  logic [AW-1:0]    req_dst,
    input  logic [PW-1:0]    req_port,
    input  logic [CW-1:0]    req_words,
    output logic [NQ-1:0]    req_full,
    output logic             rd_valid,
    output logic [AW-1:0]    rd_addr,
    output logic [CTXW-1:0]  rd_ctx,
    input  logic             rdata_valid,
    input  logic [DW-1:0]    rdata,
    input  logic [CTXW-1:0]  rdata_ctx,
    output logic [NDST-1:0]  wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    input  logic [NDST-1:0]  dst_free,
    output logic             done_valid,
    output logic [QIW-1:0]   done_qid
);
    localparam int CRW = $clog2(CREDITS + 1);

    desc_t                     new_desc;
    desc_t                     q_head [NQ];
    logic [NQ-1:0]             q_push;
    logic [NQ-1:0]             q_full;
    logic [NQ-1:0]             q_hv;
    logic [NQ-1:0]             q_last;
    logic [NQ-1:0]             elig;
    logic [NQ-1:0]             grant;
    logic [QIW-1:0]            gidx;
    logic                      gany;
    desc_t                     sel;
    logic [NDST-1:0]           take;
    logic [NDST-1:0]           cred_avail;
    logic [NDST-1:0][CRW-1:0]  cred_level;
    ctx_t                      rd_ctx_q;

    assign new_desc = '{src: req_src, dst: req_dst, port: req_port, words: req_words};

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign q_push[q] = req_valid && (req_qid == QIW'(q)) && !q_full[q]
                           && (req_words != '0);
        assign elig[q]   = q_hv[q] && cred_avail[q_head[q].port];

        xs_queue #(.DEPTH(QDEPTH)) u_q (
            .clk        (clk),
            .rst        (rst),
            .push       (q_push[q]),
            .push_desc  (new_desc),
            .advance    (grant[q]),
            .full       (q_full[q]),
            .head_valid (q_hv[q]),
            .head       (q_head[q]),
            .head_last  (q_last[q])
        );
    end

    assign req_full = q_full;

    xs_prio_arb #(.N(NQ), .IW(QIW)) u_arb (
        .req   (elig),
        .grant (grant),
        .idx   (gidx),
        .any   (gany)
    );

    assign sel  = q_head[gidx];
    assign take = gany ? (NDST'(1) << sel.port) : '0;

    xs_credit #(.NDST(NDST), .CREDITS(CREDITS), .CRW(CRW)) u_cred (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .ret   (dst_free),
        .avail (cred_avail),
        .level (cred_level)
    );

    // issue stage
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= gany;
        end
    end

    always_ff @(posedge clk) begin
        if (gany) begin
            rd_addr  <= sel.src;
            rd_ctx_q <= '{last: q_last[gidx], dst: sel.dst, port: sel.port, qid: gidx};
        end
    end

    assign rd_ctx = rd_ctx_q;

    xs_writer u_wr (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rdata_valid),
        .in_data    (rdata),
        .in_ctx     (ctx_t'(rdata_ctx)),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done_valid (done_valid),
        .done_qid   (done_qid)
    );

endmodule

// File: rtl/xfer_sched_chk.sv
module xfer_sched_chk
    import xs_pkg::*;
#(
    parameter int CREDITS = 4,
    parameter int CRW     = $clog2(CREDITS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NQ-1:0]             grant,
    input  logic                      gany,
    input  logic                      rd_valid,
    input  logic [NQ-1:0]             q_full,
    input  logic [NQ-1:0]             q_push,
    input  logic [NDST-1:0]           take,
    input  logic [NDST-1:0]           dst_free,
    input  logic [NDST-1:0][CRW-1:0]  cred_level,
    input  logic [NDST-1:0]           wr_valid,
    input  logic                      done_valid
);
    // R3: one winner per cycle
    a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3: a read leaves only after a grant
    a_r3_issue_follows_grant: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(gany));

    // R1: a full queue never accepts
    for (genvar q = 0; q < NQ; q++) begin : g_q
        a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
            q_full[q] |-> !q_push[q]);
    end

    for (genvar p = 0; p < NDST; p++) begin : g_p
        // R6: no read toward a port without credit
        a_r6_no_issue_without_credit: assert property (@(posedge clk) disable iff (rst)
            take[p] |-> (cred_level[p] != '0));
        // R7: the counter never exceeds its reset value
        a_r7_credit_cap: assert property (@(posedge clk) disable iff (rst)
            cred_level[p] <= CRW'(CREDITS));
        // R7: a return with no take adds one credit
        a_r7_return_adds_one: assert property (@(posedge clk) disable iff (rst)
            (dst_free[p] && !take[p] && (cred_level[p] < CRW'(CREDITS)))
            |=> (cred_level[p] == $past(cred_level[p]) + CRW'(1)));
    end

    // R8: a write goes to one port only
    a_r8_onehot_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_valid));

    // R9: completion only together with a write
    a_r9_done_with_write: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (|wr_valid));

endmodule

bind xfer_sched xfer_sched_chk #(.CREDITS(CREDITS), .CRW(CRW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .grant      (grant),
    .gany       (gany),
    .rd_valid   (rd_valid),
    .q_full     (q_full),
    .q_push     (q_push),
    .take       (take),
    .dst_free   (dst_free),
    .cred_level (cred_level),
    .wr_valid   (wr_valid),
    .done_valid (done_valid)
);

// File: tb/xfer_sched_test.sv
`timescale 1ns/1ps
module xfer_sched_test;
    import xs_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [QIW-1:0]   req_qid = '0;
    logic [AW-1:0]    req_src = '0;
    logic [AW-1:0]    req_dst = '0;
    logic [PW-1:0]    req_port = '0;
    logic [CW-1:0]    req_words = '0;
    logic [NQ-1:0]    req_full;
    logic             rd_valid;
    logic [AW-1:0]    rd_addr;
    logic [CTXW-1:0]  rd_ctx;
    logic             rdata_valid = 1'b0;
    logic [DW-1:0]    rdata = '0;
    logic [CTXW-1:0]  rdata_ctx = '0;
    logic [NDST-1:0]  wr_valid;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;
    logic [NDST-1:0]  dst_free = '0;
    logic             done_valid;
    logic [QIW-1:0]   done_qid;

    always #2.5 clk = ~clk;

    xfer_sched uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_qid(req_qid), .req_src(req_src),
        .req_dst(req_dst), .req_port(req_port), .req_words(req_words),
        .req_full(req_full),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ctx(rd_ctx),
        .rdata_valid(rdata_valid), .rdata(rdata), .rdata_ctx(rdata_ctx),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .dst_free(dst_free),
        .done_valid(done_valid), .done_qid(done_qid)
    );

    typedef struct packed {
        logic          last;
        logic [PW-1:0] port;
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
    } wexp_t;

    wexp_t          exp_wr [NQ][$];
    logic [AW-1:0]  exp_rd [NQ][$];
    int             issue_log[$];
    int             checks = 0;
    int             failures = 0;
    bit             auto_drain = 1'b1;
    logic [NDST-1:0] manual_free = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // source region per queue: bits [21:20] of the source address carry the queue
    function automatic logic [AW-1:0] src_of(input int q, input int off);
        return (AW'(q) << 20) | AW'(off);
    endfunction

    task automatic enq(input int q, input int off, input int dst, input int port,
                       input int words, input bit accept);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_qid   = QIW'(q);
        req_src   = src_of(q, off);
        req_dst   = AW'(dst);
        req_port  = PW'(port);
        req_words = CW'(words);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (accept) begin
            for (int i = 0; i < words; i++) begin
                exp_rd[q].push_back(src_of(q, off) + AW'(8 * i));
                exp_wr[q].push_back('{last: (i == words - 1), port: PW'(port),
                                      dst: AW'(dst) + AW'(8 * i),
                                      src: src_of(q, off) + AW'(8 * i)});
            end
        end
    endtask

    task automatic free_pulse(input int port);
        @(posedge clk); #1;
        manual_free[port] = 1'b1;
        @(posedge clk); #1;
        manual_free = '0;
    endtask

    function automatic int pending();
        int n = 0;
        for (int q = 0; q < NQ; q++) n += exp_wr[q].size();
        return n;
    endfunction

    task automatic wait_drain();
        for (int i = 0; i < 400 && pending() != 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // monitor, source model and drain model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (rd_valid) begin
                    int q;
                    q = int'(rd_ctx[QIW-1:0]);
                    issue_log.push_back(q);
                    if (exp_rd[q].size() == 0) begin
                        chk(1'b0, "R2 unexpected read", rd_addr, 0);
                    end else begin
                        logic [AW-1:0] e;
                        e = exp_rd[q].pop_front();
                        chk(rd_addr == e, "R5 read address", rd_addr, e);
                    end
                end
                if (|wr_valid) begin
                    logic [AW-1:0] s;
                    int q;
                    s = wr_data[DW-1:AW];
                    q = int'(s[21:20]);
                    if (exp_wr[q].size() == 0) begin
                        chk(1'b0, "R1 unexpected write", wr_addr, 0);
                    end else begin
                        wexp_t w;
                        w = exp_wr[q].pop_front();
                        chk(wr_addr == w.dst, "R5 write address", wr_addr, w.dst);
                        chk(s == w.src, "R4 beat order", s, w.src);
                        chk(wr_data[AW-1:0] == ~w.src, "R8 write data", wr_data[AW-1:0], ~w.src);
                        chk(wr_valid == (NDST'(1) << w.port), "R8 write port", wr_valid,
                            NDST'(1) << w.port);
                        chk(done_valid == w.last, "R9 done on last beat", done_valid, w.last);
                        if (w.last)
                            chk(done_qid == QIW'(q), "R9 done queue", done_qid, q);
                    end
                end else if (done_valid) begin
                    chk(1'b0, "R9 done without write", done_valid, 0);
                end
            end
            rdata_valid = rd_valid && !rst;
            rdata       = {rd_addr, ~rd_addr};
            rdata_ctx   = rd_ctx;
            dst_free    = (auto_drain ? wr_valid : '0) | manual_free;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(rd_valid == 1'b0, "R10 no read after reset", rd_valid, 0);
        chk(wr_valid == '0, "R10 no write after reset", wr_valid, 0);
        chk(done_valid == 1'b0, "R10 no done after reset", done_valid, 0);
        chk(req_full == '0, "R10 full flags low", req_full, 0);

        // basic transfer
        enq(0, 'h40, 'h8000, 0, 3, 1'b1);
        wait_drain();
        chk(pending() == 0, "R5 basic transfer complete", pending(), 0);

        // starve port 1, then priority by single credit returns
        auto_drain = 1'b0;
        enq(0, 'h100, 'h9000, 1, 4, 1'b1);
        repeat (20) @(posedge clk);
        base = issue_log.size();
        enq(3, 'h200, 'hA000, 1, 2, 1'b1);
        enq(2, 'h300, 'hB000, 1, 1, 1'b1);
        enq(1, 'h400, 'hC000, 1, 2, 1'b1);
        repeat (10) @(posedge clk);
        chk(issue_log.size() == base, "R6 no read to a port without credit",
            issue_log.size(), base);
        enq(0, 'h500, 'hD000, 0, 2, 1'b1);
        repeat (10) @(posedge clk);
        chk(issue_log.size() == base + 2, "R6 other port not blocked",
            issue_log.size(), base + 2);
        base = base + 2;
        begin
            int order [5] = '{1, 1, 2, 3, 3};
            for (int k = 0; k < 5; k++) begin
                free_pulse(1);
                repeat (6) @(posedge clk);
                chk(issue_log.size() == base + k + 1, "R7 one read per returned credit",
                    issue_log.size(), base + k + 1);
                if (issue_log.size() == base + k + 1)
                    chk(issue_log[base + k] == order[k], "R3 priority winner",
                        issue_log[base + k], order[k]);
            end
        end
        repeat (6) @(posedge clk);
        chk(pending() == 0, "R4 blocked queues drain in order", pending(), 0);

        // queue full and discarded requests (port 1 still without credit)
        for (int k = 0; k < 4; k++)
            enq(2, 'h800 + k * 'h40, 'h10000 + k * 'h100, 1, 2, 1'b1);
        repeat (2) @(posedge clk);
        #1;
        chk(req_full[2] == 1'b1, "R1 full at four entries", req_full[2], 1);
        chk(req_full[0] == 1'b0, "R1 other queue not full", req_full[0], 0);
        enq(2, 'hC00, 'h18000, 1, 2, 1'b0);
        base = issue_log.size();
        enq(1, 'h600, 'hE000, 0, 0, 1'b0);
        repeat (8) @(posedge clk);
        chk(issue_log.size() == base, "R2 zero-word request issues nothing",
            issue_log.size(), base);
        auto_drain = 1'b1;
        for (int k = 0; k < 4; k++) free_pulse(1);
        free_pulse(0);
        free_pulse(0);
        wait_drain();
        #1;
        chk(pending() == 0, "R4 queued transfers complete", pending(), 0);
        chk(req_full[2] == 1'b0, "R1 full clears after drain", req_full[2], 0);

        // mixed traffic over all queues and both ports
        for (int r = 0; r < 3; r++)
            for (int q = 0; q < NQ; q++)
                enq(q, 'h1000 + r * 'h100, 'h20000 + q * 'h1000 + r * 'h100,
                    (q + r) % 2, 1 + (q + r) % 4, 1'b1);
        wait_drain();
        for (int q = 0; q < NQ; q++) begin
            chk(exp_rd[q].size() == 0, "R5 all reads issued", exp_rd[q].size(), 0);
            chk(exp_wr[q].size() == 0, "R4 all writes seen", exp_wr[q].size(), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule